// File: doc/BRIEF.md
# Gate Driver Fault Supervisor

This block collects the protection flags of a two-switch gate driver (a high-side and a low-side switch of one half bridge) and turns them into a single stored fault. Each switch supplies a desaturation comparator flag, and the shared supply supplies an undervoltage flag. Any qualified flag trips the stored fault. While the fault is stored, a block output holds both PWM channels off and an active-low error line reports the condition to the controller.

A desaturation flag only counts while its switch is commanded on and after a blanking window that follows each turn-on command. This window masks the collector-voltage transient of a switch that is still turning on. The undervoltage flag counts at all times. No external reset exists. The stored fault releases itself at the first clock edge where both PWM commands are low together (the dead-time gap). Blocking therefore lasts until the end of the current switching period, unless a fault source is still active at that edge.

The fault flags come from outside the clock domain and pass through a two-stage synchronizer. The PWM commands are assumed to be generated on the same clock.

Top module: `gdrv_fault_sup`

## Requirements
- R1: While `rst` is high, and after the edge that samples it high, `block_o` is 0 and `err_n` is 1.
- R2: A fault flag takes effect two clock edges after the edge that first samples it. If a qualified flag is first sampled at edge N, `block_o` rises after edge N+2 and not before.
- R3: A desaturation flag on either channel i (bit i of `desat_flag`, bit 0 paired with `pwm_cmd[0]`) trips the stored fault when it is qualified at an edge. Qualified means its command bit is high and its blanking window has ended.
- R4: For channel i, the desaturation flag is ignored during BLANK_CYC consecutive edges that start at each edge sampling a rising edge of `pwm_cmd[i]`. A new rising edge restarts the window.
- R5: A desaturation flag of a channel whose command bit is low has no effect on `block_o`.
- R6: The undervoltage flag `uv_flag` trips the stored fault regardless of the PWM commands.
- R7: Once tripped, the fault stays stored at every edge where at least one PWM command bit is high.
- R8: At an edge that samples `pwm_cmd == 2'b00` with no qualified fault source present, the stored fault clears. `block_o` falls and `err_n` rises right after that edge.
- R9: At an edge that samples `pwm_cmd == 2'b00` while a fault source is still qualified (such as a persisting undervoltage), the fault stays stored instead of clearing.
- R10: `err_n` is low exactly when `block_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pwm_cmd | input | 2 | PWM commands, bit 0 high-side switch, bit 1 low-side switch, 1 = on |
| desat_flag | input | 2 | Desaturation comparator flags, bit i for switch i, 1 = desaturated |
| uv_flag | input | 1 | Supply undervoltage flag, 1 = undervoltage |
| block_o | output | 1 | 1 = both PWM channels blocked |
| err_n | output | 1 | Active-low fault report |

## Verification
The hardest situation to reach is a desaturation flag that lands close to the end of a blanking window, or while the window is being restarted. That requires a turn-on command, a flag and a short off-on pulse on the same channel, all at chosen cycle distances through a two-stage synchronizer. Directed sequences place the flag on the turn-on edge and retrigger the command in the middle of the window, then check the last blanked edge and the first unblanked edge. Random switching periods with varied dead times, occasional overlapping commands and sparse flag pulses then sweep the other alignments, checked against a cycle model in the bench.

// File: rtl/gdrv_fault_pkg.sv
package gdrv_fault_pkg;

    // number of gate channels supervised (one half bridge)
    localparam int NCH = 2;

    // fault flags as they enter the synchronizer
    typedef struct packed {
        logic           uv;
        logic [NCH-1:0] desat;
    } flt_vec_t;

    localparam int FLT_W = $bits(flt_vec_t);

    typedef enum logic {
        FS_CLEAR   = 1'b0,
        FS_TRIPPED = 1'b1
    } fstate_e;

    // merge qualified sources into one trip request
    function automatic logic merge_fault(input flt_vec_t q);
        return q.uv | (|q.desat);
    endfunction

endpackage

// File: rtl/fsup_sync.sv
module fsup_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
    end

    for (genvar k = 1; k < STAGES; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[k] <= '0;
            else     stg[k] <= stg[k-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/fsup_blank.sv
module fsup_blank #(
    parameter int BLANK_CYC = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic cmd,
    input  logic desat_s,
    output logic qual
);
    localparam int CW = (BLANK_CYC < 2) ? 1 : $clog2(BLANK_CYC + 1);
    localparam logic [CW-1:0] RELOAD = CW'(BLANK_CYC - 1);

    logic          cmd_d;
    logic [CW-1:0] cnt;
    logic          rise;
    logic          blanking;

    assign rise     = cmd & ~cmd_d;
    assign blanking = rise | (cnt != '0);
    assign qual     = desat_s & cmd & ~blanking;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_d <= 1'b0;
            cnt   <= '0;
        end else begin
            cmd_d <= cmd;
            if (rise)
                cnt <= RELOAD;
            else if (cnt != '0)
                cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/fsup_latch.sv
module fsup_latch
    import gdrv_fault_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    both_low,
    input  logic    evt,
    output fstate_e state
);
    fstate_e state_nx;

    always_comb begin
        if (evt)
            state_nx = FS_TRIPPED;
        else if (both_low)
            state_nx = FS_CLEAR;
        else
            state_nx = state;
    end

    always_ff @(posedge clk) begin
        if (rst) state <= FS_CLEAR;
        else     state <= state_nx;
    end
endmodule

// File: rtl/gdrv_fault_sup.sv
module gdrv_fault_sup
    import gdrv_fault_pkg::*;
#(
    parameter int BLANK_CYC   = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] pwm_cmd,
    input  logic [NCH-1:0] desat_flag,
    input  logic           uv_flag,
    output logic           block_o,
    output logic           err_n
);
    flt_vec_t       raw_flt;
    flt_vec_t       syn_flt;
    flt_vec_t       qual_flt;
    logic [NCH-1:0] desat_q;
    logic           fault_evt;
    logic           both_low;
    fstate_e        fstate;

    assign raw_flt.uv    = uv_flag;
    assign raw_flt.desat = desat_flag;

    fsup_sync #(.W(FLT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_flt),
        .q   (syn_flt)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        fsup_blank #(.BLANK_CYC(BLANK_CYC)) u_blank (
            .clk     (clk),
            .rst     (rst),
            .cmd     (pwm_cmd[i]),
            .desat_s (syn_flt.desat[i]),
            .qual    (desat_q[i])
        );
    end

    assign qual_flt.uv    = syn_flt.uv;
    assign qual_flt.desat = desat_q;
    assign fault_evt      = merge_fault(qual_flt);
    assign both_low       = ~|pwm_cmd;

    fsup_latch u_latch (
        .clk      (clk),
        .rst      (rst),
        .both_low (both_low),
        .evt      (fault_evt),
        .state    (fstate)
    );

    assign block_o = (fstate == FS_TRIPPED);
    assign err_n   = (fstate != FS_TRIPPED);
endmodule

// File: rtl/gdrv_fault_sup_chk.sv
module gdrv_fault_sup_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] pwm_cmd,
    input logic       block_o,
    input logic       err_n,
    input logic       fault_evt,
    input logic [1:0] desat_q
);
    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (!block_o && err_n));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (block_o && (pwm_cmd != 2'b00)) |=> block_o);

    // R8
    release_chk: assert property (@(posedge clk) disable iff (rst)
        ((pwm_cmd == 2'b00) && !fault_evt) |=> (!block_o && err_n));

    // R9
    relatch_chk: assert property (@(posedge clk) disable iff (rst)
        fault_evt |=> (block_o && !err_n));

    // R4
    blank_a_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pwm_cmd[0]) |-> !desat_q[0]);

    // R4
    blank_b_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pwm_cmd[1]) |-> !desat_q[1]);

    // R10
    err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(err_n) |-> $past(fault_evt));
endmodule

bind gdrv_fault_sup gdrv_fault_sup_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .pwm_cmd   (pwm_cmd),
    .block_o   (block_o),
    .err_n     (err_n),
    .fault_evt (fault_evt),
    .desat_q   (desat_q)
);

// File: tb/tb_gdrv_fault_sup.sv
module tb_gdrv_fault_sup;
    localparam int CLK_PERIOD = 10;
    localparam int BLANK      = 6;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] pwm_cmd = 2'b00;
    logic [1:0] desat_flag = 2'b00;
    logic       uv_flag = 1'b0;
    logic       block_o;
    logic       err_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gdrv_fault_sup #(.BLANK_CYC(BLANK), .SYNC_STAGES(2)) dut (
        .clk        (clk),
        .rst        (rst),
        .pwm_cmd    (pwm_cmd),
        .desat_flag (desat_flag),
        .uv_flag    (uv_flag),
        .block_o    (block_o),
        .err_n      (err_n)
    );

    // ---------------- reference model built from the requirements
    logic [2:0] m_s1, m_s2;   // {uv, desat[1], desat[0]}
    logic [1:0] m_pd;
    int         m_cnt [2];
    logic       m_lat;

    function automatic logic ch_qual(input logic flag_s, input logic cmd,
                                     input logic cmd_prev, input int cnt);
        logic in_window;
        in_window = (cmd && !cmd_prev) || (cnt != 0);
        return flag_s && cmd && !in_window;
    endfunction

    function automatic int cnt_next(input logic cmd, input logic cmd_prev,
                                    input int cnt);
        if (cmd && !cmd_prev) return BLANK - 1;
        if (cnt != 0)         return cnt - 1;
        return 0;
    endfunction

    function automatic logic lat_next(input logic lat, input logic ev,
                                      input logic [1:0] pwm);
        if (ev)            return 1'b1;
        if (pwm == 2'b00)  return 1'b0;
        return lat;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_s1 = '0; m_s2 = '0; m_pd = '0; m_lat = 1'b0;
            m_cnt[0] = 0; m_cnt[1] = 0;
        end else begin
            logic q0, q1, ev;
            q0 = ch_qual(m_s2[0], pwm_cmd[0], m_pd[0], m_cnt[0]);
            q1 = ch_qual(m_s2[1], pwm_cmd[1], m_pd[1], m_cnt[1]);
            ev = q0 || q1 || m_s2[2];
            m_lat    = lat_next(m_lat, ev, pwm_cmd);
            m_cnt[0] = cnt_next(pwm_cmd[0], m_pd[0], m_cnt[0]);
            m_cnt[1] = cnt_next(pwm_cmd[1], m_pd[1], m_cnt[1]);
            m_pd = pwm_cmd;
            m_s2 = m_s1;
            m_s1 = {uv_flag, desat_flag};
        end
    end

    // ---------------- helpers
    task automatic check(input bit ok, input string req,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic check_out(input string req, input logic exp_blk);
        check(block_o === exp_blk, req, int'(block_o), int'(exp_blk));
        check(err_n === !exp_blk, {req, " R10 err_n"}, int'(err_n), int'(!exp_blk));
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    int uv_run = 0;

    task automatic rnd_cycle(input logic [1:0] pwm);
        @(negedge clk);
        check_out("model", m_lat);
        pwm_cmd       = pwm;
        desat_flag[0] = ($urandom % 45) == 0;
        desat_flag[1] = ($urandom % 45) == 0;
        if (uv_run > 0) begin
            uv_run--;
            uv_flag = 1'b1;
        end else begin
            uv_flag = 1'b0;
            if (($urandom % 300) == 0) uv_run = 1 + ($urandom % 30);
        end
    endtask

    // ---------------- watchdog
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // ---------------- stimulus
    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1;
        wait_n(4);
        // R1 reset state
        check_out("R1 reset", 1'b0);
        rst = 1'b0;
        wait_n(2);
        check_out("R1 after reset", 1'b0);

        // R4 / R3: flag present from the turn-on edge of channel 0
        pwm_cmd = 2'b01; desat_flag = 2'b01;
        wait_n(BLANK);
        check_out("R4 blanked ch0", 1'b0);
        wait_n(1);
        check_out("R3 ch0 desat trips", 1'b1);

        // R7: other switch on, fault must persist
        pwm_cmd = 2'b10; desat_flag = 2'b00;
        wait_n(4);
        check_out("R7 hold", 1'b1);

        // R8: both low, no source -> release
        pwm_cmd = 2'b00;
        wait_n(1);
        check_out("R8 release", 1'b0);

        // R5: flag on a switch that is commanded off
        pwm_cmd = 2'b10; desat_flag = 2'b01;
        wait_n(10);
        check_out("R5 off switch ignored", 1'b0);
        pwm_cmd = 2'b00; desat_flag = 2'b00;
        wait_n(3);

        // R2 / R6 / R9: undervoltage with both commands low
        uv_flag = 1'b1;
        wait_n(2);
        check_out("R2 sync latency", 1'b0);
        wait_n(1);
        check_out("R6 uv trips", 1'b1);
        wait_n(5);
        check_out("R9 relatch while uv", 1'b1);
        uv_flag = 1'b0;
        wait_n(2);
        check_out("R9 uv still in sync", 1'b1);
        wait_n(1);
        check_out("R8 release after uv", 1'b0);

        // R3 channel 1 after its window, R2 latency
        pwm_cmd = 2'b10;
        wait_n(10);
        desat_flag = 2'b10;
        wait_n(2);
        check_out("R2 desat latency", 1'b0);
        wait_n(1);
        check_out("R3 ch1 desat trips", 1'b1);
        pwm_cmd = 2'b00; desat_flag = 2'b00;
        wait_n(3);
        check_out("R8 release ch1", 1'b0);

        // R4 restart: retrigger command inside the window
        pwm_cmd = 2'b10; desat_flag = 2'b10;
        wait_n(3);
        pwm_cmd = 2'b00;
        wait_n(1);
        pwm_cmd = 2'b10;
        wait_n(BLANK);
        check_out("R4 window restarted", 1'b0);
        wait_n(1);
        check_out("R3 trip after restart", 1'b1);
        pwm_cmd = 2'b00; desat_flag = 2'b00;
        wait_n(4);
        check_out("R8 clean", 1'b0);

        // constrained random switching periods
        for (int p = 0; p < 500; p++) begin
            int on0, on1, dt0, dt1;
            bit ovl;
            on0 = 1 + ($urandom % 20);
            on1 = 1 + ($urandom % 20);
            dt0 = $urandom % 4;
            dt1 = $urandom % 4;
            ovl = ($urandom % 12) == 0;
            for (int c = 0; c < on0; c++) rnd_cycle(2'b01);
            if (ovl) for (int c = 0; c < 2; c++) rnd_cycle(2'b11);
            for (int c = 0; c < dt0; c++) rnd_cycle(2'b00);
            for (int c = 0; c < on1; c++) rnd_cycle(2'b10);
            for (int c = 0; c < dt1; c++) rnd_cycle(2'b00);
        end

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule